// File: doc/BRIEF.md
# Dual-Clock Ready-Flag FIFO

This block carries data words from a write clock domain to an independent read clock domain. Words are written into a dual-port storage array on the write clock. On the read side, the oldest word is moved automatically into an output register as soon as it becomes visible, so the word at the head of the queue is already on the output before any read request arrives. Each domain sees its own pair of flags. The read side has an output-ready flag and an almost-empty flag. The write side has an input-ready flag and an almost-full flag.

Pointers pass between the domains as Gray code through two-stage synchronizers. A write therefore reaches the output register only after a fixed number of read-clock edges, and a slot freed by a read becomes writable only after a fixed number of write-clock edges. The almost-empty and almost-full thresholds are offset registers held on the write side. Their values after reset come from parameters, and a load strobe on the write side can replace them. The occupancy that drives both almost flags counts the words in the array only. The word in the output register is not counted. Total capacity is therefore DEPTH + 1 words. DEPTH must be a power of two.

Top module: `xclk_rdy_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released with no traffic, `out_ready` is 0, `almost_empty_n` is 0, `almost_full_n` is 1 and `in_ready` is 1.
- R2: Words leave in the order they were accepted. While `out_ready` is 1, `rd_data` is the oldest unread word. A read is a cycle with `rd_en` high while `out_ready` is high. It consumes that word on the rising `rclk` edge, and the output holds the word until it is read.
- R3: While `out_ready` is 0, `rd_data` keeps the last word that was read, and `rd_en` has no effect. No word is lost or skipped.
- R4: After a word is written into an empty FIFO, `out_ready` rises on the third rising `rclk` edge after the write edge, counting from the first `rclk` edge that follows the write edge. The word is on `rd_data` from that edge.
- R5: The FIFO accepts exactly DEPTH + 1 words before `in_ready` settles low. A write while `in_ready` is 0 is ignored.
- R6: When the FIFO is full, a read makes `in_ready` rise on the second rising `wclk` edge after the read edge. It stays low after the first of these edges.
- R7: `almost_empty_n` is 0 while the array holds X words or fewer, and 1 while it holds X+1 or more, where X is the almost-empty offset.
- R8: `almost_full_n` is 1 while the array holds DEPTH-1-Y words or fewer, and 0 while it holds DEPTH-Y or more, where Y is the almost-full offset. `almost_full_n` is always 0 when `in_ready` is 0.
- R9: A word moved into the output register no longer counts toward array occupancy for either almost flag.
- R10: After reset, X equals parameter `AE_RST` and Y equals `AF_RST`. A `wclk` cycle with `cfg_ld` high loads X from `cfg_ae` and Y from `cfg_af`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request, taken when `in_ready` is high |
| wr_data | input | WIDTH | Word to write |
| cfg_ld | input | 1 | Load the offset registers (write domain) |
| cfg_ae | input | $clog2(DEPTH) | New almost-empty offset X |
| cfg_af | input | $clog2(DEPTH) | New almost-full offset Y |
| in_ready | output | 1 | At least one array slot is free (write domain) |
| almost_full_n | output | 1 | Low when the array holds DEPTH-Y or more words (write domain) |
| rd_en | input | 1 | Read request, taken when `out_ready` is high |
| rd_data | output | WIDTH | Output register |
| out_ready | output | 1 | Output register holds an unread word (read domain) |
| almost_empty_n | output | 1 | High when the array holds more than X words (read domain) |

## Verification
The hardest state to reach from the ports is a completely full FIFO: the array holds DEPTH words and one more word waits in the output register. Reaching it needs write bursts that keep going until `in_ready` stays low after both synchronizers have settled. A single read from that state then shows the two-edge delay before a slot can be written again. The almost-full boundary is reached the same way, by draining one word at a time from full. The almost-empty boundary is approached by writing exactly X+1 and then X+2 words. Constrained random traffic at several write and read rates then checks ordering through wrap-around under concurrent activity in both domains.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

    // Reflected binary code of a value
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Inverse of bin_to_gray: prefix xor from the top bit down
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl #(
    parameter int DEPTH  = 512,
    parameter int AE_RST = 16,
    parameter int AF_RST = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          cfg_ld,
    input  logic [AW-1:0] cfg_ae,
    input  logic [AW-1:0] cfg_af,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wptr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] ae_off,
    output logic          in_ready,
    output logic          almost_full_n
);
    import xfifo_pkg::*;

    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
    } wst_t;

    wst_t          s_d, s_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;

    always_comb begin
        rbin          = PW'(gray_to_bin(32'(rgray_s)));
        used          = s_q.ptr - rbin;
        in_ready      = (used != FULL_CNT);
        we            = wr_en & in_ready;
        almost_full_n = (used + {1'b0, s_q.af}) < FULL_CNT;

        s_d = s_q;
        if (we) begin
            s_d.ptr = s_q.ptr + PW'(1);
        end
        s_d.gray = PW'(bin_to_gray(32'(s_d.ptr)));
        if (cfg_ld) begin
            s_d.ae = cfg_ae;
            s_d.af = cfg_af;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ptr  <= '0;
            s_q.gray <= '0;
            s_q.ae   <= AW'(AE_RST);
            s_q.af   <= AW'(AF_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign wptr   = s_q.ptr;
    assign wgray  = s_q.gray;
    assign waddr  = s_q.ptr[AW-1:0];
    assign ae_off = s_q.ae;
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ae_s,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] rptr,
    output logic          ld,
    output logic [AW-1:0] raddr,
    output logic          out_ready,
    output logic          almost_empty_n
);
    import xfifo_pkg::*;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          ordy;
    } rst_t;

    rst_t          s_d, s_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] held;
    logic          avail;
    logic          consume;

    always_comb begin
        wbin           = PW'(gray_to_bin(32'(wgray_s)));
        held           = wbin - s_q.ptr;
        avail          = (held != '0);
        consume        = s_q.ordy & rd_en;
        // fall-through: refill when the register is empty or being emptied
        ld             = avail & (~s_q.ordy | consume);
        almost_empty_n = held > {1'b0, ae_s};

        s_d      = s_q;
        s_d.ptr  = s_q.ptr + PW'(ld);
        s_d.gray = PW'(bin_to_gray(32'(s_d.ptr)));
        s_d.ordy = ld | (s_q.ordy & ~consume);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rptr      = s_q.ptr;
    assign rgray     = s_q.gray;
    assign raddr     = s_q.ptr[AW-1:0];
    assign out_ready = s_q.ordy;
endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
module xfifo_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] dout_d, dout_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        dout_d = ld ? mem[raddr] : dout_q;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign rdata = dout_q;
endmodule

// File: rtl/xclk_rdy_fifo.sv
`timescale 1ns/1ps
module xclk_rdy_fifo #(
    parameter int DEPTH  = 512,
    parameter int WIDTH  = 36,
    parameter int AE_RST = 16,
    parameter int AF_RST = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cfg_ld,
    input  logic [AW-1:0]    cfg_ae,
    input  logic [AW-1:0]    cfg_af,
    output logic             in_ready,
    output logic             almost_full_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_ready,
    output logic             almost_empty_n
);
    logic [PW-1:0] wgray, wgray_s, wptr_bin;
    logic [PW-1:0] rgray, rgray_s, rptr_bin;
    logic [AW-1:0] waddr, raddr, ae_off, ae_s;
    logic          we, ld;

    xfifo_wr_ctl #(.DEPTH(DEPTH), .AE_RST(AE_RST), .AF_RST(AF_RST)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en),
        .cfg_ld(cfg_ld), .cfg_ae(cfg_ae), .cfg_af(cfg_af),
        .rgray_s(rgray_s), .wgray(wgray), .wptr(wptr_bin),
        .we(we), .waddr(waddr), .ae_off(ae_off),
        .in_ready(in_ready), .almost_full_n(almost_full_n)
    );

    xfifo_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    // offset is quasi-static: reloaded only while traffic is idle
    xfifo_sync #(.W(AW)) u_ae2r (
        .clk(rclk), .rst_n(rst_n), .d(ae_off), .q(ae_s)
    );

    xfifo_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    xfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en),
        .wgray_s(wgray_s), .ae_s(ae_s), .rgray(rgray), .rptr(rptr_bin),
        .ld(ld), .raddr(raddr), .out_ready(out_ready),
        .almost_empty_n(almost_empty_n)
    );

    xfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rst_n(rst_n), .ld(ld), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/xclk_rdy_fifo_chk.sv
`timescale 1ns/1ps
module xclk_rdy_fifo_chk #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 36,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             in_ready,
    input logic             almost_full_n,
    input logic             out_ready,
    input logic [WIDTH-1:0] rd_data,
    input logic [PW-1:0]    wptr,
    input logic [PW-1:0]    rptr
);
    // R5
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !in_ready) |=> $stable(wptr));

    // R5
    occupancy_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wptr - rptr) <= PW'(DEPTH));

    // R8
    full_implies_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !in_ready |-> !almost_full_n);

    // R3
    idle_output_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !out_ready |=> (out_ready || $stable(rd_data)));

    // R2
    unread_word_kept_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (out_ready && !rd_en) |=> ($stable(rptr) && $stable(rd_data)));

    // R4
    ready_needs_load_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(out_ready) |-> (rptr != $past(rptr)));
endmodule

bind xclk_rdy_fifo xclk_rdy_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .in_ready(in_ready), .almost_full_n(almost_full_n), .out_ready(out_ready),
    .rd_data(rd_data), .wptr(wptr_bin), .rptr(rptr_bin)
);

// File: tb/sim_xclk_rdy_fifo.sv
`timescale 1ns/1ps
module sim_xclk_rdy_fifo;
    localparam int  CLK_PERIOD = 10;
    localparam real RCLK_HALF  = 6.5;
    localparam int  DEPTH      = 512;
    localparam int  WIDTH      = 36;
    localparam int  AW         = 9;
    localparam int  AE_RST     = 16;
    localparam int  AF_RST     = 16;

    logic             wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic             wr_en = 1'b0, rd_en = 1'b0, cfg_ld = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0]    cfg_ae = '0, cfg_af = '0;
    logic             in_ready, almost_full_n, out_ready, almost_empty_n;
    logic [WIDTH-1:0] rd_data;

    int               checks = 0, errors = 0;
    logic [WIDTH-1:0] sb[$];
    logic [WIDTH-1:0] last_pop = '0;
    int               cur_x = AE_RST, cur_y = AF_RST;
    bit               wdone = 1'b0;

    xclk_rdy_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AE_RST(AE_RST), .AF_RST(AF_RST)) u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_ld(cfg_ld), .cfg_ae(cfg_ae), .cfg_af(cfg_af),
        .in_ready(in_ready), .almost_full_n(almost_full_n),
        .rd_en(rd_en), .rd_data(rd_data), .out_ready(out_ready),
        .almost_empty_n(almost_empty_n)
    );

    initial forever #(CLK_PERIOD/2) wclk = ~wclk;
    initial begin
        #2.3;
        forever #(RCLK_HALF) rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit exp_ae_n(input int arr, input int x);
        return arr > x;
    endfunction

    function automatic bit exp_af_n(input int arr, input int y);
        return arr <= DEPTH - 1 - y;
    endfunction

    function automatic logic [WIDTH-1:0] rnd_word();
        return WIDTH'({$urandom, $urandom});
    endfunction

    task automatic push(input logic [WIDTH-1:0] d);
        bit acc;
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        acc     = in_ready;
        @(posedge wclk);
        wr_en <= 1'b0;
        if (acc) sb.push_back(d);
    endtask

    task automatic pop(input string req);
        @(negedge rclk);
        chk(req, 64'(out_ready), 64'd1);
        if (sb.size() > 0) chk(req, 64'(rd_data), 64'(sb[0]));
        rd_en = 1'b1;
        @(posedge rclk);
        rd_en <= 1'b0;
        if (sb.size() > 0) last_pop = sb.pop_front();
    endtask

    task automatic settle();
        repeat (10) @(posedge rclk);
        #1;
    endtask

    task automatic check_flags(input string req);
        int tot, arr;
        tot = sb.size();
        arr = (tot > 0) ? tot - 1 : 0;
        chk(req, 64'(out_ready),      64'(tot > 0));
        chk(req, 64'(almost_empty_n), 64'(exp_ae_n(arr, cur_x)));
        chk(req, 64'(almost_full_n),  64'(exp_af_n(arr, cur_y)));
        chk(req, 64'(in_ready),       64'(arr < DEPTH));
    endtask

    task automatic program_offsets(input int x, input int y);
        @(negedge wclk);
        cfg_ld = 1'b1;
        cfg_ae = AW'(x);
        cfg_af = AW'(y);
        @(posedge wclk);
        cfg_ld <= 1'b0;
        cur_x = x;
        cur_y = y;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));

        // R1 reset state
        repeat (3) @(posedge wclk);
        #1;
        chk("R1", 64'(out_ready), 64'd0);
        chk("R1", 64'(almost_empty_n), 64'd0);
        chk("R1", 64'(almost_full_n), 64'd1);
        chk("R1", 64'(in_ready), 64'd1);
        @(negedge wclk);
        rst_n = 1'b1;
        settle();
        check_flags("R1");

        // R4 fall-through latency in read-clock edges
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = 36'h0ABCD1234;
        @(posedge wclk);
        wr_en <= 1'b0;
        sb.push_back(36'h0ABCD1234);
        for (int k = 1; k <= 3; k++) begin
            @(posedge rclk);
            #1;
            chk("R4", 64'(out_ready), 64'(k == 3));
        end
        chk("R4", 64'(rd_data), 64'h0ABCD1234);

        // R3 reads while empty are ignored and data holds
        pop("R2");
        @(negedge rclk);
        rd_en = 1'b1;
        repeat (5) @(posedge rclk);
        #1;
        chk("R3", 64'(out_ready), 64'd0);
        chk("R3", 64'(rd_data), 64'(last_pop));
        @(negedge rclk);
        rd_en = 1'b0;
        push(36'h155AA0F0F);
        settle();
        chk("R3", 64'(out_ready), 64'd1);
        chk("R3", 64'(rd_data), 64'h155AA0F0F);
        pop("R2");

        // R7 R9 R10 default almost-empty offset boundary
        for (int i = 0; i < AE_RST + 1; i++) push(rnd_word());
        settle();
        check_flags("R10");
        chk("R9", 64'(almost_empty_n), 64'd0);
        push(rnd_word());
        settle();
        chk("R7", 64'(almost_empty_n), 64'd1);
        while (sb.size() > 0) pop("R2");
        settle();
        check_flags("R3");

        // R10 programmed offsets
        program_offsets(3, 5);
        settle();
        for (int i = 0; i < 4; i++) push(rnd_word());
        settle();
        chk("R10", 64'(almost_empty_n), 64'd0);
        push(rnd_word());
        settle();
        chk("R10", 64'(almost_empty_n), 64'd1);
        check_flags("R7");

        // R5 fill to full capacity
        forever begin
            while (in_ready) push(rnd_word());
            settle();
            if (!in_ready) break;
        end
        chk("R5", 64'(sb.size()), 64'(DEPTH + 1));
        check_flags("R8");
        push(36'hBADBADBAD);
        settle();
        chk("R5", 64'(sb.size()), 64'(DEPTH + 1));
        chk("R5", 64'(in_ready), 64'd0);

        // R6 freed slot visible on second write-clock edge
        pop("R2");
        @(posedge wclk);
        #1;
        chk("R6", 64'(in_ready), 64'd0);
        @(posedge wclk);
        #1;
        chk("R6", 64'(in_ready), 64'd1);

        // R8 almost-full boundary with Y=5
        while (sb.size() > DEPTH - 5 + 1) pop("R2");
        settle();
        chk("R8", 64'(almost_full_n), 64'd0);
        check_flags("R8");
        pop("R2");
        settle();
        chk("R8", 64'(almost_full_n), 64'd1);
        check_flags("R9");
        while (sb.size() > 0) pop("R2");
        settle();
        check_flags("R2");

        // random traffic at several rates
        program_offsets(20, 30);
        settle();
        fork
            begin
                for (int i = 0; i < 3000; i++) begin
                    int wp;
                    wp = (i < 1000) ? 30 : ((i < 2000) ? 90 : 60);
                    @(negedge wclk);
                    wr_en   = (($urandom % 100) < wp);
                    wr_data = rnd_word();
                    if (wr_en && in_ready) sb.push_back(wr_data);
                end
                @(negedge wclk);
                wr_en = 1'b0;
                wdone = 1'b1;
            end
            begin
                int n;
                n = 0;
                while (!wdone || sb.size() > 0) begin
                    int rp;
                    rp = (n < 1500) ? 80 : ((n < 3000) ? 25 : 95);
                    @(negedge rclk);
                    rd_en = (($urandom % 100) < rp);
                    if (rd_en && out_ready) begin
                        chk("R2", 64'(rd_data), 64'(sb[0]));
                        void'(sb.pop_front());
                    end
                    n++;
                end
                @(negedge rclk);
                rd_en = 1'b0;
            end
        join
        settle();
        check_flags("R2");
        finish_run();
    end
endmodule